// File: doc/BRIEF.md
# Call Termination Controller

This block follows the life of a single paging call across a stream of codewords that an upstream decoder has already classified. Each codeword arrives with a one-cycle strobe, a two-bit kind code, a flag that marks it as uncorrectable, and an address-match flag. A call opens when a clean address codeword that matches the receiver is accepted. From then on the block watches the codewords that follow. It closes the call when the message ends normally, or when the uncorrectable codewords break the error policy that is selected.

Two static policy inputs pick one of three error policies. In the default policy the call ends on two back-to-back uncorrectable codewords, or on one uncorrectable codeword in the slot right after the address. The second policy ends the call on any single uncorrectable codeword. The third ends it only on a run of uncorrectable codewords of the configured length. When the call closes, the block gives a one-cycle end pulse and a two-bit cause code, and the cause code keeps its value until the next close.

Kind encoding: 0 idle, 1 address, 2 message, and 3 is treated as a message. Cause encoding: 0 idle received, 1 new address received, 2 error policy tripped.

Top module: `call_term_ctrl`

## Requirements
- R1: After reset, call_active is 0, end_of_call is 0 and end_reason is 0.
- R2: While no call is active, a strobed codeword of kind 1 (address) with addr_match=1 and cw_uncorr=0 sets call_active in the cycle after the strobe edge.
- R3: While no call is active, every other codeword is ignored: idle, message, an address without a match, and any codeword with cw_uncorr=1. call_active and end_of_call stay 0.
- R4: Once a clean message codeword (kind 2 or 3) has been accepted in the call, a clean idle codeword (kind 0) ends the call with end_reason 0.
- R5: Once a clean message codeword has been accepted in the call, a clean address codeword (kind 1, whatever the match flag) ends the call with end_reason 1.
- R6: Before the first clean message codeword of a call, clean idle and address codewords do not end the call.
- R7: With pol_single=0 (pol_pair ignored), an uncorrectable codeword in the slot directly after the opening address ends the call with end_reason 2.
- R8: With pol_single=0, two consecutive uncorrectable codewords end the call with end_reason 2. A single uncorrectable codeword that is not in the first slot does not end it.
- R9: With pol_single=1 and pol_pair=0, any single uncorrectable codeword ends the call with end_reason 2.
- R10: With pol_single=1 and pol_pair=1, only ERR_RUN (default 2) consecutive uncorrectable codewords end the call. One uncorrectable codeword in the first slot does not end it.
- R11: Any codeword with cw_uncorr=0, whatever its kind, clears the consecutive-error count.
- R12: end_of_call is a one-cycle pulse, and call_active falls in that same cycle. end_reason changes only when end_of_call is raised and holds its value between pulses.
- R13: A codeword with cw_uncorr=1 counts only as an error, whatever its kind: it never ends a call through R4 or R5 and never opens one.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cw_valid | input | 1 | One-cycle strobe for a classified codeword |
| cw_kind | input | 2 | Codeword kind: 0 idle, 1 address, 2/3 message |
| cw_uncorr | input | 1 | Codeword could not be corrected |
| addr_match | input | 1 | Address codeword belongs to this receiver |
| pol_single | input | 1 | Error policy select, upper bit |
| pol_pair | input | 1 | Error policy select, lower bit |
| call_active | output | 1 | A call is in progress |
| end_of_call | output | 1 | One-cycle pulse when a call closes |
| end_reason | output | 2 | Cause of the last close: 0 idle, 1 address, 2 errors |

## Verification
If the call state is wrong, the fault shows up on the codeword that should end the call. A state stuck before the message phase swallows the terminating idle or address, so call_active stays high when it should fall. A state that enters the message phase too early closes the call on an idle that should have been harmless. A stale or missing clear of the error run counter changes whether the second uncorrectable codeword ends the call, so the fault shows on end_of_call one codeword after the counter went wrong. Each scenario therefore places the codeword that decides the outcome right after the one that sets up the state, and checks the ports one cycle after that decisive strobe.

// File: rtl/ctc_pkg.sv
package ctc_pkg;

  typedef enum logic [1:0] {
    KIND_IDLE = 2'd0,
    KIND_ADDR = 2'd1,
    KIND_MSG  = 2'd2,
    KIND_RSVD = 2'd3
  } cw_kind_e;

  typedef enum logic [1:0] {
    END_IDLE = 2'd0,
    END_ADDR = 2'd1,
    END_ERR  = 2'd2,
    END_NONE = 2'd3
  } end_cause_e;

  typedef enum logic [1:0] {
    ST_OFF   = 2'd0,
    ST_FIRST = 2'd1,
    ST_WAIT  = 2'd2,
    ST_MSG   = 2'd3
  } call_state_e;

  typedef struct packed {
    logic hit_addr;
    logic good_idle;
    logic good_addr;
    logic good_msg;
    logic bad;
  } cw_event_t;

endpackage

// File: rtl/ctc_cw_decode.sv
module ctc_cw_decode
  import ctc_pkg::*;
(
  input  logic       cw_valid,
  input  logic [1:0] cw_kind,
  input  logic       cw_uncorr,
  input  logic       addr_match,
  output cw_event_t  ev
);

  logic clean;

  always_comb begin
    clean        = cw_valid && !cw_uncorr;
    ev.bad       = cw_valid && cw_uncorr;
    ev.good_idle = clean && (cw_kind == KIND_IDLE);
    ev.good_addr = clean && (cw_kind == KIND_ADDR);
    ev.good_msg  = clean && ((cw_kind == KIND_MSG) || (cw_kind == KIND_RSVD));
    ev.hit_addr  = clean && (cw_kind == KIND_ADDR) && addr_match;
  end

endmodule

// File: rtl/ctc_err_policy.sv
module ctc_err_policy #(
  parameter int ERR_RUN = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic in_call,
  input  logic first_slot,
  input  logic ev_good,
  input  logic ev_bad,
  input  logic pol_single,
  input  logic pol_pair,
  output logic trip
);

  localparam int CW = $clog2(ERR_RUN + 1);
  localparam logic [CW-1:0] RUN_MAX = CW'(ERR_RUN);

  logic [CW-1:0] run_cnt;
  logic          run_hit;
  logic          mode_single;
  logic          mode_first;

  always_ff @(posedge clk) begin
    if (rst || !in_call) begin
      run_cnt <= '0;
    end else if (ev_bad) begin
      if (run_cnt != RUN_MAX) run_cnt <= run_cnt + CW'(1);
    end else if (ev_good) begin
      run_cnt <= '0;
    end
  end

  always_comb begin
    run_hit     = ({1'b0, run_cnt} + (CW+1)'(1)) >= (CW+1)'(ERR_RUN);
    mode_single = pol_single && !pol_pair;
    mode_first  = !pol_single && first_slot;
    trip        = in_call && ev_bad && (mode_single || mode_first || run_hit);
  end

  p_run_bounded_r11: assert property (@(posedge clk) disable iff (rst)
    run_cnt <= RUN_MAX);

  p_good_clears_r11: assert property (@(posedge clk) disable iff (rst)
    (in_call && ev_good && !ev_bad) |=> (run_cnt == '0));

endmodule

// File: rtl/ctc_call_fsm.sv
module ctc_call_fsm
  import ctc_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  cw_event_t   ev,
  input  logic        trip,
  output call_state_e state,
  output logic        call_active,
  output logic        end_of_call,
  output logic [1:0]  end_reason
);

  call_state_e nxt;
  end_cause_e  cause;
  end_cause_e  reason_q;
  logic        fire;

  always_comb begin
    nxt   = state;
    fire  = 1'b0;
    cause = reason_q;
    unique case (state)
      ST_OFF: begin
        if (ev.hit_addr) nxt = ST_FIRST;
      end
      ST_FIRST, ST_WAIT: begin
        if (trip) begin
          fire  = 1'b1;
          cause = END_ERR;
        end else if (ev.good_msg) begin
          nxt = ST_MSG;
        end else if (ev.good_idle || ev.good_addr || ev.bad) begin
          nxt = ST_WAIT;
        end
      end
      ST_MSG: begin
        if (trip) begin
          fire  = 1'b1;
          cause = END_ERR;
        end else if (ev.good_idle) begin
          fire  = 1'b1;
          cause = END_IDLE;
        end else if (ev.good_addr) begin
          fire  = 1'b1;
          cause = END_ADDR;
        end
      end
      default: nxt = ST_OFF;
    endcase
    if (fire) nxt = ST_OFF;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state       <= ST_OFF;
      call_active <= 1'b0;
      end_of_call <= 1'b0;
      reason_q    <= END_IDLE;
    end else begin
      state       <= nxt;
      call_active <= (nxt != ST_OFF);
      end_of_call <= fire;
      if (fire) reason_q <= cause;
    end
  end

  assign end_reason = reason_q;

  p_pulse_once_r12: assert property (@(posedge clk) disable iff (rst)
    end_of_call |=> !end_of_call);

  p_drop_with_end_r12: assert property (@(posedge clk) disable iff (rst)
    end_of_call |-> (!call_active && $past(call_active)));

  p_reason_hold_r12: assert property (@(posedge clk) disable iff (rst)
    !end_of_call |-> $stable(end_reason));

  p_state_matches_flag_r2: assert property (@(posedge clk) disable iff (rst)
    call_active == (state != ST_OFF));

endmodule

// File: rtl/call_term_ctrl.sv
module call_term_ctrl
  import ctc_pkg::*;
#(
  parameter int ERR_RUN = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       cw_valid,
  input  logic [1:0] cw_kind,
  input  logic       cw_uncorr,
  input  logic       addr_match,
  input  logic       pol_single,
  input  logic       pol_pair,
  output logic       call_active,
  output logic       end_of_call,
  output logic [1:0] end_reason
);

  cw_event_t   ev;
  call_state_e state;
  logic        trip;
  logic        in_call;
  logic        first_slot;

  ctc_cw_decode u_decode (
    .cw_valid   (cw_valid),
    .cw_kind    (cw_kind),
    .cw_uncorr  (cw_uncorr),
    .addr_match (addr_match),
    .ev         (ev)
  );

  assign in_call    = (state != ST_OFF);
  assign first_slot = (state == ST_FIRST);

  ctc_err_policy #(.ERR_RUN(ERR_RUN)) u_policy (
    .clk        (clk),
    .rst        (rst),
    .in_call    (in_call),
    .first_slot (first_slot),
    .ev_good    (ev.good_idle || ev.good_addr || ev.good_msg),
    .ev_bad     (ev.bad),
    .pol_single (pol_single),
    .pol_pair   (pol_pair),
    .trip       (trip)
  );

  ctc_call_fsm u_fsm (
    .clk         (clk),
    .rst         (rst),
    .ev          (ev),
    .trip        (trip),
    .state       (state),
    .call_active (call_active),
    .end_of_call (end_of_call),
    .end_reason  (end_reason)
  );

  p_quiet_r3: assert property (@(posedge clk) disable iff (rst)
    !cw_valid |=> (!end_of_call && $stable(call_active)));

  p_open_r2: assert property (@(posedge clk) disable iff (rst)
    $rose(call_active) |-> $past(cw_valid && cw_kind == 2'd1 && addr_match && !cw_uncorr));

  p_single_trip_r9: assert property (@(posedge clk) disable iff (rst)
    (call_active && cw_valid && cw_uncorr && pol_single && !pol_pair)
      |=> (end_of_call && end_reason == 2'd2));

  p_err_cause_r13: assert property (@(posedge clk) disable iff (rst)
    (call_active && cw_valid && cw_uncorr) |=> (!end_of_call || end_reason == 2'd2));

endmodule

// File: tb/tb_call_term_ctrl.sv
module tb_call_term_ctrl;

  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst;
  logic       cw_valid;
  logic [1:0] cw_kind;
  logic       cw_uncorr;
  logic       addr_match;
  logic       pol_single;
  logic       pol_pair;
  logic       call_active;
  logic       end_of_call;
  logic [1:0] end_reason;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  call_term_ctrl dut (
    .clk(clk), .rst(rst), .cw_valid(cw_valid), .cw_kind(cw_kind),
    .cw_uncorr(cw_uncorr), .addr_match(addr_match), .pol_single(pol_single),
    .pol_pair(pol_pair), .call_active(call_active), .end_of_call(end_of_call),
    .end_reason(end_reason)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // drive one codeword; returns at the falling edge after the capturing edge
  task automatic send(input logic [1:0] kind, input logic unc, input logic m);
    @(negedge clk);
    cw_valid = 1'b1; cw_kind = kind; cw_uncorr = unc; addr_match = m;
    @(negedge clk);
    cw_valid = 1'b0; cw_uncorr = 1'b0; addr_match = 1'b0;
  endtask

  task automatic expect_state(input string req, input int act_e, input int eoc_e);
    chk({req, " call_active"}, int'(call_active), act_e);
    chk({req, " end_of_call"}, int'(end_of_call), eoc_e);
  endtask

  task automatic open_call(input string req);
    send(2'd1, 1'b0, 1'b1);
    expect_state(req, 1, 0);
  endtask

  task automatic set_pol(input logic a, input logic b);
    pol_single = a; pol_pair = b;
  endtask

  task automatic t_reset;
    chk("R1 call_active", int'(call_active), 0);
    chk("R1 end_of_call", int'(end_of_call), 0);
    chk("R1 end_reason", int'(end_reason), 0);
  endtask

  task automatic t_ignore_open;
    set_pol(0, 0);
    send(2'd0, 0, 0); expect_state("R3 idle", 0, 0);
    send(2'd2, 0, 0); expect_state("R3 msg", 0, 0);
    send(2'd1, 0, 0); expect_state("R3 nomatch", 0, 0);
    send(2'd1, 1, 1); expect_state("R3 R13 uncorr addr", 0, 0);
    send(2'd2, 1, 0); expect_state("R3 error", 0, 0);
    open_call("R2 open");
    send(2'd2, 0, 0);
    send(2'd0, 0, 0); expect_state("R2 close", 0, 1);
  endtask

  task automatic t_idle_end;
    set_pol(0, 0);
    open_call("R4 open");
    send(2'd2, 0, 0); send(2'd3, 0, 0); expect_state("R4 msgs", 1, 0);
    send(2'd0, 0, 0); expect_state("R4 idle end", 0, 1);
    chk("R4 reason", int'(end_reason), 0);
    @(negedge clk);
    chk("R12 pulse width", int'(end_of_call), 0);
    chk("R12 inactive", int'(call_active), 0);
  endtask

  task automatic t_addr_end;
    set_pol(0, 0);
    open_call("R5 open");
    send(2'd2, 0, 0);
    send(2'd1, 0, 0); expect_state("R5 addr end", 0, 1);
    chk("R5 reason", int'(end_reason), 1);
    repeat (3) @(negedge clk);
    chk("R12 reason held", int'(end_reason), 1);
  endtask

  task automatic t_premsg;
    set_pol(0, 0);
    open_call("R6 open");
    send(2'd0, 0, 0); expect_state("R6 idle early", 1, 0);
    send(2'd1, 0, 1); expect_state("R6 addr early", 1, 0);
    send(2'd2, 0, 0);
    send(2'd0, 0, 0); expect_state("R6 later idle end", 0, 1);
  endtask

  task automatic t_first_err;
    set_pol(0, 1);
    open_call("R7 open");
    send(2'd2, 1, 0); expect_state("R7 first slot error", 0, 1);
    chk("R7 reason", int'(end_reason), 2);
  endtask

  task automatic t_pair_default;
    set_pol(0, 0);
    open_call("R8 open");
    send(2'd2, 0, 0);
    send(2'd2, 1, 0); expect_state("R8 one error", 1, 0);
    send(2'd2, 1, 0); expect_state("R8 two errors", 0, 1);
    chk("R8 reason", int'(end_reason), 2);
  endtask

  task automatic t_single;
    set_pol(1, 0);
    open_call("R9 open");
    send(2'd2, 0, 0);
    send(2'd2, 1, 0); expect_state("R9 single error", 0, 1);
    chk("R9 reason", int'(end_reason), 2);
    open_call("R9 reopen");
    send(2'd0, 1, 0); expect_state("R9 first slot error", 0, 1);
  endtask

  task automatic t_pair_only;
    set_pol(1, 1);
    open_call("R10 open");
    send(2'd2, 1, 0); expect_state("R10 first slot tolerated", 1, 0);
    send(2'd2, 1, 0); expect_state("R10 two errors", 0, 1);
    chk("R10 reason", int'(end_reason), 2);
  endtask

  task automatic t_clear;
    set_pol(1, 1);
    open_call("R11 open");
    send(2'd2, 0, 0);
    send(2'd2, 1, 0);
    send(2'd2, 0, 0);
    send(2'd2, 1, 0); expect_state("R11 cleared by message", 1, 0);
    send(2'd2, 0, 0);
    send(2'd0, 0, 0); expect_state("R11 idle end", 0, 1);
    set_pol(0, 0);
    open_call("R11 open b");
    send(2'd0, 0, 0);
    send(2'd2, 1, 0);
    send(2'd1, 0, 0);
    send(2'd2, 1, 0); expect_state("R11 cleared by address", 1, 0);
    send(2'd2, 1, 0); expect_state("R11 run end", 0, 1);
  endtask

  task automatic t_kind_on_err;
    set_pol(1, 1);
    open_call("R13 open");
    send(2'd2, 0, 0);
    send(2'd0, 1, 0); expect_state("R13 bad idle no end", 1, 0);
    send(2'd1, 1, 1); expect_state("R13 bad addr error run", 0, 1);
    chk("R13 reason", int'(end_reason), 2);
  endtask

  initial begin
    rst = 1'b1; cw_valid = 1'b0; cw_kind = 2'd0; cw_uncorr = 1'b0;
    addr_match = 1'b0; pol_single = 1'b0; pol_pair = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_ignore_open();
    t_idle_end();
    t_addr_end();
    t_premsg();
    t_first_err();
    t_pair_default();
    t_single();
    t_pair_only();
    t_clear();
    t_kind_on_err();
    repeat (2) @(negedge clk);
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

endmodule